// File: doc/BRIEF.md
# Storage Window Mapper

This block holds the configuration of a movable, resizable window in a flat 32-bit address space. Behind the window sits cell storage that other logic implements. Software programs two 64-bit map registers over a simple strobe-based register port. The first register places the window base and switches the window on or off. The second sets an address-mask field that fixes the window size and a small entry-grain field. It also carries a read-only count of storage cells.

From the current configuration the block drives the window base, the size and the enable. It also drives a combinational hit flag for a probe address, which fabric logic uses to steer accesses into the storage. A write that would give a size other than a power of two changes the register but leaves the active size alone. The block also gives the reset tag pattern of every storage cell, FIFO cells first and semaphore cells after them, so that the storage can start in a known state.

Top module: `storage_window_mapper`

## Requirements
- R1: The register index is the byte address with its three low bits dropped, so `reg_addr[2:0]` has no effect. Index 0 selects map register A and index 1 selects map register B.
- R2: A write to register A loads `reg_wdata[31:10]` (window base) and `reg_wdata[0]` (enable). Every other bit of A keeps its previous value.
- R3: A write to register B loads `reg_wdata[16:10]` (address mask) and `reg_wdata[2:0]` (grain). Every other bit of B keeps its previous value, including the cell count at bit `COUNT_LSB` upward.
- R4: A write to any index above 1 changes neither register and pulses `reg_wr_err` high for exactly the cycle after the strobe. A read of such an index returns zero.
- R5: The candidate size is 1024 plus B masked to bits 16:10. The block adopts it only when it is a power of two and otherwise keeps the previous size. Base, enable and size are re-derived only on a write that alters a stored register value.
- R6: `win_base` is A[31:10] followed by ten zero bits, and `win_en` is A[0]. `probe_hit` is high exactly when `win_en` is set and (`probe_addr` − `win_base`) modulo 2^32 is below `win_size`, so a window may wrap past the top of the address space.
- R7: After reset A is zero. B holds (`RST_WIN_BYTES` − 1) masked to bits 16:10, with the total cell count placed at bit `COUNT_LSB`. The window is disabled, with base 0 and size `RST_WIN_BYTES`.
- R8: `cell_tags` holds one 6-bit tag per cell, with cell 0 in the lowest bits: bit 0 is empty, bit 1 is FIFO-type, and bits 5:2 are the depth code. Cells below `NUM_FIFO` carry empty=1, FIFO=1 and depth `FIFO_DEPTH_CODE`. Semaphore cells carry all zeros.
- R9: A read returns the full 64-bit register, read-only fields included, on `reg_rdata` in the cycle after the strobe, and the data holds until the next read. A configuration write is visible on the window outputs in the cycle after the strobe. A read together with a write to the same index returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_wr_err | output | 1 | One-cycle pulse after a write to an unmapped index |
| probe_addr | input | 32 | Address tested against the window |
| probe_hit | output | 1 | Probe address lies inside the enabled window |
| win_base | output | 32 | Current window base |
| win_size | output | 32 | Current window size in bytes |
| win_en | output | 1 | Window enable |
| cell_tags | output | 6*(NUM_FIFO+NUM_SEM) | Reset tag of every cell |

## Verification
The bench builds the block with three FIFO cells, two semaphore cells and depth code 9. With five cells the count field is not a power of two, FIFO and semaphore tags sit side by side in `cell_tags`, and a distinctive depth code shows up in the FIFO tags. The register index width stays at five bits, so writes and reads can reach both the highest unmapped index and byte addresses with nonzero low bits. Probes are placed one byte inside and one byte outside both window edges in every cycle. This covers a window that wraps past 0xFFFFFFFF and every size step from 1 KiB up to 128 KiB.

// File: rtl/wmap_pkg.sv
`timescale 1ns/1ps
package wmap_pkg;

   localparam int unsigned MAP_W    = 64;
   localparam int unsigned AW       = 32;
   localparam int unsigned MASK_LSB = 10;
   localparam int unsigned MASK_W   = 7;
   localparam int unsigned BASE_W   = AW - MASK_LSB;
   localparam int unsigned MIN_WIN  = 1024;
   localparam int unsigned MAX_WIN  = 131072;
   localparam int unsigned MAX_CELL_KIND = 16;

   // writable bits of each map register
   localparam logic [MAP_W-1:0] A_WMASK   = 64'h0000_0000_FFFF_FC01;
   localparam logic [MAP_W-1:0] B_WMASK   = 64'h0000_0000_0001_FC07;
   localparam logic [MAP_W-1:0] B_SZFIELD = 64'h0000_0000_0001_FC00;

   typedef struct packed {
      logic [3:0] depth;
      logic       fifo;
      logic       empty;
   } cell_tag_t;

   localparam int unsigned TAG_W = $bits(cell_tag_t);

   function automatic logic [AW-1:0] size_from_mask(input logic [MASK_W-1:0] m);
      return AW'(MIN_WIN) + {{(AW-MASK_W-MASK_LSB){1'b0}}, m, {MASK_LSB{1'b0}}};
   endfunction

   function automatic logic is_pow2(input logic [AW-1:0] v);
      return (v != '0) && ((v & (v - AW'(1))) == '0);
   endfunction

endpackage

// File: rtl/wmap_regs.sv
`timescale 1ns/1ps
module wmap_regs
   import wmap_pkg::*;
#(
   parameter int unsigned     REG_AW = 8,
   parameter logic [63:0]     RST_B  = 64'h0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [REG_AW-1:0]    addr,
   input  logic [MAP_W-1:0]     wdata,
   output logic [MAP_W-1:0]     rdata,
   output logic                 wr_err,
   output logic [BASE_W-1:0]    nxt_base,
   output logic                 nxt_en,
   output logic [MASK_W-1:0]    nxt_mask,
   output logic                 cfg_chg
);

   localparam int unsigned IDX_W = REG_AW - 3;

   logic [IDX_W-1:0] idx;
   logic [MAP_W-1:0] map_a, map_b, map_a_d, map_b_d;
   logic             sel_a, sel_b, sel_bad;

   assign idx     = addr[REG_AW-1:3];
   assign sel_a   = wr_en && (idx == IDX_W'(0));
   assign sel_b   = wr_en && (idx == IDX_W'(1));
   assign sel_bad = wr_en && (idx > IDX_W'(1));

   always_comb begin
      map_a_d = map_a;
      map_b_d = map_b;
      if (sel_a) map_a_d = (wdata & A_WMASK) | (map_a & ~A_WMASK);
      if (sel_b) map_b_d = (wdata & B_WMASK) | (map_b & ~B_WMASK);
   end

   assign cfg_chg  = (map_a_d != map_a) || (map_b_d != map_b);
   assign nxt_base = map_a_d[AW-1:MASK_LSB];
   assign nxt_en   = map_a_d[0];
   assign nxt_mask = map_b_d[MASK_LSB+MASK_W-1:MASK_LSB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_a  <= '0;
         map_b  <= RST_B;
         rdata  <= '0;
         wr_err <= 1'b0;
      end else begin
         map_a  <= map_a_d;
         map_b  <= map_b_d;
         wr_err <= sel_bad;
         if (rd_en) begin
            unique case (idx)
               IDX_W'(0): rdata <= map_a;
               IDX_W'(1): rdata <= map_b;
               default:   rdata <= '0;
            endcase
         end
      end
   end

   AST_A_RO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      sel_a |=> (map_a & ~A_WMASK) == $past(map_a & ~A_WMASK)); // R2
   AST_B_RO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      sel_b |=> (map_b & ~B_WMASK) == $past(map_b & ~B_WMASK)); // R3
   AST_BAD_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      sel_bad |=> wr_err); // R4
   AST_NO_WR_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !wr_err); // R4
   AST_BAD_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      sel_bad |=> $stable(map_a) && $stable(map_b)); // R4
   AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && idx > IDX_W'(1)) |=> rdata == '0); // R4
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R9

endmodule

// File: rtl/wmap_window.sv
`timescale 1ns/1ps
module wmap_window
   import wmap_pkg::*;
#(
   parameter int unsigned RST_SIZE = 4096
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_chg,
   input  logic [BASE_W-1:0]    nxt_base,
   input  logic                 nxt_en,
   input  logic [MASK_W-1:0]    nxt_mask,
   input  logic [AW-1:0]        probe_addr,
   output logic                 probe_hit,
   output logic [AW-1:0]        win_base,
   output logic [AW-1:0]        win_size,
   output logic                 win_en
);

   logic [AW-1:0] cand;
   logic [AW-1:0] offset;

   assign cand = size_from_mask(nxt_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_base <= '0;
         win_en   <= 1'b0;
         win_size <= AW'(RST_SIZE);
      end else if (cfg_chg) begin
         win_base <= {nxt_base, {MASK_LSB{1'b0}}};
         win_en   <= nxt_en;
         if (is_pow2(cand)) win_size <= cand;
      end
   end

   // modular offset lets a window wrap past the top of the space
   assign offset    = probe_addr - win_base;
   assign probe_hit = win_en && (offset < win_size);

   AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(win_size) == 1); // R5
   AST_HOLD_NO_CHG: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_chg |=> $stable(win_size) && $stable(win_base) && $stable(win_en)); // R5
   AST_BASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> win_base[AW-1:MASK_LSB] == $past(nxt_base)); // R6
   AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      probe_hit |-> win_en); // R6

endmodule

// File: rtl/wmap_cell_tags.sv
`timescale 1ns/1ps
module wmap_cell_tags
   import wmap_pkg::*;
#(
   parameter int unsigned NUM_FIFO   = 16,
   parameter int unsigned NUM_SEM    = 16,
   parameter int unsigned DEPTH_CODE = 2,
   localparam int unsigned NUM_CELLS = NUM_FIFO + NUM_SEM
)(
   output logic [NUM_CELLS*TAG_W-1:0] tags
);

   for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
      cell_tag_t t;
      if (c < NUM_FIFO) begin : g_fifo
         assign t = '{depth: 4'(DEPTH_CODE), fifo: 1'b1, empty: 1'b1};
      end else begin : g_sem
         assign t = '0;
      end
      assign tags[c*TAG_W +: TAG_W] = t;
   end

endmodule

// File: rtl/storage_window_mapper.sv
`timescale 1ns/1ps
module storage_window_mapper
   import wmap_pkg::*;
#(
   parameter int unsigned NUM_FIFO        = 16,
   parameter int unsigned NUM_SEM         = 16,
   parameter int unsigned FIFO_DEPTH_CODE = 2,
   parameter int unsigned REG_AW          = 8,
   parameter int unsigned COUNT_LSB       = 20,
   parameter int unsigned RST_WIN_BYTES   = 4096,
   localparam int unsigned NUM_CELLS      = NUM_FIFO + NUM_SEM
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr_en,
   input  logic                       reg_rd_en,
   input  logic [REG_AW-1:0]          reg_addr,
   input  logic [63:0]                reg_wdata,
   output logic [63:0]                reg_rdata,
   output logic                       reg_wr_err,
   input  logic [31:0]                probe_addr,
   output logic                       probe_hit,
   output logic [31:0]                win_base,
   output logic [31:0]                win_size,
   output logic                       win_en,
   output logic [NUM_CELLS*6-1:0]     cell_tags
);

   localparam logic [63:0] RST_B =
      (64'(RST_WIN_BYTES - 1) & B_SZFIELD) | (64'(NUM_CELLS) << COUNT_LSB);

   if (NUM_FIFO > MAX_CELL_KIND) begin : g_chk_fifo
      $error("NUM_FIFO above 16");
   end
   if (NUM_SEM > MAX_CELL_KIND) begin : g_chk_sem
      $error("NUM_SEM above 16");
   end
   if (NUM_CELLS < 1) begin : g_chk_cells
      $error("at least one cell required");
   end
   if (FIFO_DEPTH_CODE > 15) begin : g_chk_depth
      $error("FIFO_DEPTH_CODE must fit four bits");
   end
   if (REG_AW < 4 || REG_AW > 16) begin : g_chk_aw
      $error("REG_AW out of range");
   end
   if (COUNT_LSB < 17 || COUNT_LSB > 58) begin : g_chk_cnt
      $error("COUNT_LSB overlaps a writable field or overflows");
   end
   if (RST_WIN_BYTES < MIN_WIN || RST_WIN_BYTES > MAX_WIN ||
       (RST_WIN_BYTES & (RST_WIN_BYTES - 1)) != 0) begin : g_chk_win
      $error("RST_WIN_BYTES must be a power of two in 1K..128K");
   end

   logic [BASE_W-1:0] nxt_base;
   logic              nxt_en;
   logic [MASK_W-1:0] nxt_mask;
   logic              cfg_chg;

   wmap_regs #(
      .REG_AW (REG_AW),
      .RST_B  (RST_B)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .rd_en    (reg_rd_en),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .wr_err   (reg_wr_err),
      .nxt_base (nxt_base),
      .nxt_en   (nxt_en),
      .nxt_mask (nxt_mask),
      .cfg_chg  (cfg_chg)
   );

   wmap_window #(
      .RST_SIZE (RST_WIN_BYTES)
   ) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_chg    (cfg_chg),
      .nxt_base   (nxt_base),
      .nxt_en     (nxt_en),
      .nxt_mask   (nxt_mask),
      .probe_addr (probe_addr),
      .probe_hit  (probe_hit),
      .win_base   (win_base),
      .win_size   (win_size),
      .win_en     (win_en)
   );

   wmap_cell_tags #(
      .NUM_FIFO   (NUM_FIFO),
      .NUM_SEM    (NUM_SEM),
      .DEPTH_CODE (FIFO_DEPTH_CODE)
   ) u_tags (
      .tags (cell_tags)
   );

   AST_WR_REACHES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr[REG_AW-1:3] == '0 && reg_wdata[0] != win_en) |=> win_en == $past(reg_wdata[0])); // R9

endmodule

// File: tb/storage_window_mapper_tb.sv
`timescale 1ns/1ps
module storage_window_mapper_tb_top;

   localparam int NF = 3;
   localparam int NS = 2;
   localparam int NC = NF + NS;
   localparam int DC = 9;
   localparam int AWR = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr_en = 1'b0;
   logic              reg_rd_en = 1'b0;
   logic [AWR-1:0]    reg_addr = '0;
   logic [63:0]       reg_wdata = '0;
   logic [63:0]       reg_rdata;
   logic              reg_wr_err;
   logic [31:0]       probe_addr = '0;
   logic              probe_hit;
   logic [31:0]       win_base, win_size;
   logic              win_en;
   logic [NC*6-1:0]   cell_tags;

   storage_window_mapper #(
      .NUM_FIFO (NF), .NUM_SEM (NS), .FIFO_DEPTH_CODE (DC),
      .REG_AW (AWR), .COUNT_LSB (20), .RST_WIN_BYTES (4096)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .reg_wr_en (reg_wr_en), .reg_rd_en (reg_rd_en),
      .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .reg_wr_err (reg_wr_err), .probe_addr (probe_addr), .probe_hit (probe_hit),
      .win_base (win_base), .win_size (win_size), .win_en (win_en),
      .cell_tags (cell_tags)
   );

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // reference model
   logic [63:0] m_a, m_b, m_rd;
   logic        m_err, m_en;
   logic [31:0] m_base, m_size;
   localparam logic [63:0] M_B_RST = 64'h0000_0C00 | (64'(NC) << 20);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_a = '0; m_b = M_B_RST; m_rd = '0; m_err = 1'b0;
         m_en = 1'b0; m_base = '0; m_size = 32'd4096;
      end else begin
         int idx;
         logic [63:0] na, nb;
         logic [31:0] cand;
         idx = int'(reg_addr) / 8;
         if (reg_rd_en) m_rd = (idx == 0) ? m_a : (idx == 1) ? m_b : 64'h0;
         m_err = 1'b0;
         if (reg_wr_en) begin
            na = m_a; nb = m_b;
            if (idx == 0)      na = {m_a[63:32], reg_wdata[31:10], m_a[9:1], reg_wdata[0]};
            else if (idx == 1) nb = {m_b[63:17], reg_wdata[16:10], m_b[9:3], reg_wdata[2:0]};
            else               m_err = 1'b1;
            if (na != m_a || nb != m_b) begin
               m_base = {na[31:10], 10'd0};
               m_en   = na[0];
               cand   = 32'd1024 + {15'd0, nb[16:10], 10'd0};
               if ($countones(cand) == 1) m_size = cand;
            end
            m_a = na; m_b = nb;
         end
      end
   end

   function automatic logic model_hit(input logic [31:0] p);
      longint off;
      off = (longint'(p) - longint'(m_base) + 64'sh1_0000_0000) % 64'sh1_0000_0000;
      return m_en && (off < longint'(m_size));
   endfunction

   logic [31:0] lfsr = 32'hACE1_2345;

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] pv [5];
         chk("R9", "rdata", reg_rdata, m_rd);
         chk("R4", "wr_err", 64'(reg_wr_err), 64'(m_err));
         chk("R6", "win_base", 64'(win_base), 64'(m_base));
         chk("R6", "win_en", 64'(win_en), 64'(m_en));
         chk("R5", "win_size", 64'(win_size), 64'(m_size));
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         pv[0] = m_base - 32'd1; pv[1] = m_base;
         pv[2] = m_base + m_size - 32'd1; pv[3] = m_base + m_size; pv[4] = lfsr;
         for (int k = 0; k < 5; k++) begin
            probe_addr = pv[k];
            #0.2;
            chk("R6", "probe_hit", 64'(probe_hit), 64'(model_hit(pv[k])));
         end
      end
   end

   task automatic wr(input logic [AWR-1:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AWR-1:0] a, input logic [63:0] exp, input string req);
      @(negedge clk);
      reg_rd_en = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd_en = 1'b0;
      #1;
      chk(req, "read value", reg_rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R7 reset state
      chk("R7", "reset size", 64'(win_size), 64'd4096);
      chk("R7", "reset enable", 64'(win_en), 64'd0);
      chk("R7", "reset base", 64'(win_base), 64'd0);
      rd(8'h00, 64'h0, "R7");
      rd(8'h08, 64'h0050_0C00, "R7");
      // R8 cell tags
      for (int c = 0; c < NC; c++)
         chk("R8", "cell tag", 64'(cell_tags[c*6 +: 6]), (c < NF) ? 64'h27 : 64'h0);
      // R2 masked write to A; window wraps past the top
      wr(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
      #1;
      chk("R6", "wrapped base", 64'(win_base), 64'hFFFF_FC00);
      rd(8'h00, 64'h0000_0000_FFFF_FC01, "R2");
      // R1 low address bits ignored, R3 masked write to B
      wr(8'h0A, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(8'h0F, 64'h0051_FC07, "R1");
      chk("R3", "size 128K", 64'(win_size), 64'h2_0000);
      // R5 non power of two keeps size
      wr(8'h08, 64'h800);
      #1;
      chk("R5", "size kept", 64'(win_size), 64'h2_0000);
      rd(8'h08, 64'h0050_0800, "R3");
      wr(8'h08, 64'h400);
      #1;
      chk("R5", "size 2K", 64'(win_size), 64'd2048);
      wr(8'h08, 64'h0);
      #1;
      chk("R5", "size 1K", 64'(win_size), 64'd1024);
      wr(8'h00, 64'h1234_5678_0001_2C01);
      rd(8'h00, 64'h0001_2C01, "R2");
      // R4 unmapped writes and reads
      wr(8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
      #1;
      chk("R4", "error pulse", 64'(reg_wr_err), 64'd1);
      rd(8'h00, 64'h0001_2C01, "R4");
      rd(8'h10, 64'h0, "R4");
      rd(8'hF8, 64'h0, "R4");
      chk("R4", "error cleared", 64'(reg_wr_err), 64'd0);
      // R9 read and write same cycle returns old value
      @(negedge clk);
      reg_wr_en = 1'b1; reg_rd_en = 1'b1; reg_addr = 8'h00; reg_wdata = 64'h0;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_rd_en = 1'b0;
      #1;
      chk("R9", "old value on overlap", reg_rdata, 64'h0001_2C01);
      chk("R6", "disabled", 64'(win_en), 64'd0);
      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         case (r[1:0])
            2'd0: wr({r[6:5] == 2'd0 ? 5'd2 : 5'd0, r[4:2]}, {$urandom, $urandom});
            2'd1: wr({5'd1, r[4:2]}, 64'(r[31:8]) << 8 | 64'(r[7:0]));
            2'd2: wr({r[9:5] | 5'd2, 3'd0}, {$urandom, $urandom});
            default: begin
               @(negedge clk);
               reg_rd_en = 1'b1; reg_addr = r[AWR+1:2];
               @(negedge clk);
               reg_rd_en = 1'b0;
            end
         endcase
      end
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule